// File: doc/BRIEF.md
# Mains-Synchronised Sawtooth Heat Regulator

This block decides, once per mains cycle, whether a resistive heater should be fired for that cycle. A zero-crossing detector supplies a single-clock enable per mains period. Each enable advances an 11-bit cycle counter. The four most significant bits of that counter select one of sixteen equal steps of a slow staircase offset. The offset is added to a digital set-point, which gives a threshold that sweeps slowly upward across a narrow proportional band. The sweep takes 2048 mains periods, which is 40.96 s at 50 Hz and about 34.13 s at 60 Hz. A digitised sensor code is compared with this moving threshold. A lower sensor code means a colder reading. As a result, a small temperature error becomes a burst duty cycle spread over tens of seconds instead of rapid on/off chatter.

Two mode inputs change the threshold. One lowers the set-point by a fixed energy-saving amount. The other switches the comparator from a narrow hysteresis to a wide one. If the sensor code rises above a failsafe level, which is what an open sensor produces, every heat request is blocked until the reading comes back. All sums and differences clamp at the ends of the 12-bit code range instead of wrapping. The block itself does not convert the sensor, build gate pulses or regulate the supply.

Top module: `sawtooth_regulator`

## Requirements
- R1: The cycle counter is 11 bits wide. It increments by one on each clock edge where `cycle_en` is high and wraps from 2047 to 0, so one ramp period lasts exactly 2048 enables.
- R2: The ramp offset equals the counter's upper 4 bits (counter bits 10 down to 7) multiplied by a step of 4 codes. This gives 16 steps per period, from 0 to 60 codes, with 64 codes per degree.
- R3: The upper threshold is `setpoint` plus the ramp offset, clamped at 4095.
- R4: When `reduce_en` is high, 320 codes (5 degrees) are subtracted from the upper threshold, clamped at 0.
- R5: While the heat request is off, it turns on at an enable where `sensor` is below the upper threshold minus the hysteresis (clamped at 0). While it is on, it stays on at an enable where `sensor` is below the upper threshold, and turns off otherwise.
- R6: The hysteresis is 10 codes (about 0.15 degree) with `wide_hyst` low and 320 codes (5 degrees) with `wide_hyst` high.
- R7: At each enable, `failsafe` takes the value of (`sensor` > 3900). When it is set, `heat_req` is forced low for that cycle.
- R8: Outside enables, the counter, `heat_req` and `failsafe` hold their values whatever the data inputs do.
- R9: When `rst_n` is low at a clock edge, the counter is cleared and both outputs go low. Reset takes priority over `cycle_en`.
- R10: The decision made at an enable uses the counter value held before that enable's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_en | input | 1 | One-clock pulse per mains period |
| setpoint | input | 12 | Set-point code |
| sensor | input | 12 | Digitised sensor code, higher is warmer |
| reduce_en | input | 1 | Apply the energy-saving set-point reduction |
| wide_hyst | input | 1 | Select the wide comparator hysteresis |
| heat_req | output | 1 | Fire the heater for this mains cycle |
| failsafe | output | 1 | Sensor reading is beyond the open-sensor level |

## Verification
The first pattern holds the sensor 30 codes above the set-point for two full ramp periods. At that distance the request turns on only in the upper steps and drops when the ramp wraps, so the run separates the step width, the bit slice, the wrap point and the hysteresis state. A sweep of sensor codes across the whole 12-bit range cycles through all four combinations of reduction and hysteresis mode. This sweep covers the comparator edges and the failsafe level. Set-points near 4095, and near 0 with reduction on, distinguish clamping from wrap-around. Bursts of input changes without an enable, and a reset asserted together with an enable, confirm the hold and reset rules.

// File: rtl/sawreg_pkg.sv
// Shared types for the sawtooth heat regulator.
// Assumes: nothing beyond the standard language.
package sawreg_pkg;

    // Heat request state kept by the decision stage.
    typedef enum logic {
        HEAT_IDLE = 1'b0,
        HEAT_FIRE = 1'b1
    } heat_state_e;

    // Threshold pair presented to the comparator.
    typedef struct packed {
        logic [11:0] upper;
        logic [11:0] lower;
    } thr_pair_t;

endpackage

// File: rtl/mains_cycle_counter.sv
// Free-running counter that advances once per mains-cycle enable.
// Assumes: cycle_en is a single-clock pulse; reset is synchronous, active low.
module mains_cycle_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_en,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count mains cycles, wrapping naturally at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (cycle_en)
            count <= count + 1'b1;
    end

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_en && count == CNT_MAX) |=> (count == '0));

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_en |=> $stable(count));

    // R9
    cnt_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0));

endmodule

// File: rtl/stair_ramp.sv
// Turns the counter's upper bits into a staircase offset code.
// Assumes: (2**STEP_BITS - 1) * STEP_LSB fits in CODE_W bits.
module stair_ramp #(
    parameter int STEP_BITS = 4,
    parameter int CODE_W    = 12,
    parameter int STEP_LSB  = 4
) (
    input  logic [STEP_BITS-1:0] step,
    output logic [CODE_W-1:0]    offset
);

    localparam bit LSB_POW2 = (STEP_LSB & (STEP_LSB - 1)) == 0;
    localparam int SHIFT    = $clog2(STEP_LSB);

    logic [CODE_W-1:0] step_ext;

    // Widen the step index to code width.
    always_comb step_ext = CODE_W'(step);

    generate
        if (LSB_POW2) begin : g_shift
            // Power-of-two step: a plain shift.
            always_comb offset = step_ext << SHIFT;
        end else begin : g_mult
            // Arbitrary step: a constant multiply.
            always_comb offset = step_ext * CODE_W'(STEP_LSB);
        end
    endgenerate

endmodule

// File: rtl/reference_builder.sv
// Builds the comparator thresholds from set-point, ramp and mode offsets.
// Assumes: all codes unsigned; every sum/difference clamps at range ends.
module reference_builder
    import sawreg_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int REDUCE_CODE = 320,
    parameter int HYST_NARROW = 10,
    parameter int HYST_WIDE   = 320
) (
    input  logic [CODE_W-1:0] setpoint,
    input  logic [CODE_W-1:0] ramp_ofs,
    input  logic              reduce_en,
    input  logic              wide_hyst,
    output logic [CODE_W-1:0] thr_upper,
    output logic [CODE_W-1:0] thr_lower
);

    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] RED_C    = CODE_W'(REDUCE_CODE);
    localparam logic [CODE_W-1:0] HN_C     = CODE_W'(HYST_NARROW);
    localparam logic [CODE_W-1:0] HW_C     = CODE_W'(HYST_WIDE);

    logic [CODE_W:0]   raw_sum;
    logic [CODE_W-1:0] sat_sum;
    logic [CODE_W-1:0] cut;
    logic [CODE_W-1:0] hyst;

    // Set-point plus ramp, clamped at the top code.
    always_comb begin
        raw_sum = {1'b0, setpoint} + {1'b0, ramp_ofs};
        sat_sum = raw_sum[CODE_W] ? CODE_MAX : raw_sum[CODE_W-1:0];
    end

    // Energy-saving reduction, clamped at zero.
    always_comb begin
        cut       = reduce_en ? RED_C : '0;
        thr_upper = (sat_sum >= cut) ? (sat_sum - cut) : '0;
    end

    // Hysteresis selection and lower turn-on level, clamped at zero.
    always_comb begin
        hyst      = wide_hyst ? HW_C : HN_C;
        thr_lower = (thr_upper >= hyst) ? (thr_upper - hyst) : '0;
    end

endmodule

// File: rtl/heat_decider.sv
// Hysteretic comparator with open-sensor inhibit, updated per mains cycle.
// Assumes: thr_lower <= thr_upper; inputs are synchronous to clk.
module heat_decider
    import sawreg_pkg::*;
#(
    parameter int CODE_W        = 12,
    parameter int FAILSAFE_CODE = 3900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_en,
    input  logic [CODE_W-1:0] sensor,
    input  logic [CODE_W-1:0] thr_upper,
    input  logic [CODE_W-1:0] thr_lower,
    output logic              heat_req,
    output logic              failsafe
);

    localparam logic [CODE_W-1:0] FS_C = CODE_W'(FAILSAFE_CODE);

    heat_state_e state_q, state_d;
    logic        fs_d;

    // Next decision from present state, sensor and thresholds.
    always_comb begin
        fs_d = (sensor > FS_C);
        if (fs_d)
            state_d = HEAT_IDLE;
        else if (state_q == HEAT_FIRE)
            state_d = (sensor < thr_upper) ? HEAT_FIRE : HEAT_IDLE;
        else
            state_d = (sensor < thr_lower) ? HEAT_FIRE : HEAT_IDLE;
    end

    // Register decision and inhibit once per mains cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= HEAT_IDLE;
            failsafe <= 1'b0;
        end else if (cycle_en) begin
            state_q  <= state_d;
            failsafe <= fs_d;
        end
    end

    // Drive the request from the state.
    always_comb heat_req = (state_q == HEAT_FIRE);

    // R7
    fs_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        failsafe |-> !heat_req);

    // R5
    heat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(heat_req) |-> ($past(sensor) < $past(thr_lower)));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_en |=> ($stable(heat_req) && $stable(failsafe)));

    // R9
    out_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!heat_req && !failsafe));

endmodule

// File: rtl/sawtooth_regulator.sv
// Top: mains-cycle counter, staircase ramp, threshold build, decision.
// Assumes: cycle_en pulses once per mains period for one clock.
module sawtooth_regulator #(
    parameter int CNT_W         = 11,
    parameter int STEP_BITS     = 4,
    parameter int CODE_W        = 12,
    parameter int STEP_LSB      = 4,
    parameter int REDUCE_CODE   = 320,
    parameter int HYST_NARROW   = 10,
    parameter int HYST_WIDE     = 320,
    parameter int FAILSAFE_CODE = 3900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_en,
    input  logic [CODE_W-1:0] setpoint,
    input  logic [CODE_W-1:0] sensor,
    input  logic              reduce_en,
    input  logic              wide_hyst,
    output logic              heat_req,
    output logic              failsafe
);

    localparam int STEP_LO = CNT_W - STEP_BITS;

    logic [CNT_W-1:0]     count;
    logic [STEP_BITS-1:0] step;
    logic [CODE_W-1:0]    ramp_ofs;
    logic [CODE_W-1:0]    thr_upper;
    logic [CODE_W-1:0]    thr_lower;

    mains_cycle_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cycle_en (cycle_en),
        .count    (count)
    );

    // Take the staircase index from the counter's top bits.
    always_comb step = count[CNT_W-1:STEP_LO];

    stair_ramp #(
        .STEP_BITS (STEP_BITS),
        .CODE_W    (CODE_W),
        .STEP_LSB  (STEP_LSB)
    ) u_ramp (
        .step   (step),
        .offset (ramp_ofs)
    );

    reference_builder #(
        .CODE_W      (CODE_W),
        .REDUCE_CODE (REDUCE_CODE),
        .HYST_NARROW (HYST_NARROW),
        .HYST_WIDE   (HYST_WIDE)
    ) u_ref (
        .setpoint  (setpoint),
        .ramp_ofs  (ramp_ofs),
        .reduce_en (reduce_en),
        .wide_hyst (wide_hyst),
        .thr_upper (thr_upper),
        .thr_lower (thr_lower)
    );

    heat_decider #(
        .CODE_W        (CODE_W),
        .FAILSAFE_CODE (FAILSAFE_CODE)
    ) u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .cycle_en  (cycle_en),
        .sensor    (sensor),
        .thr_upper (thr_upper),
        .thr_lower (thr_lower),
        .heat_req  (heat_req),
        .failsafe  (failsafe)
    );

    // R2
    ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_en |=> $stable(ramp_ofs));

    // R4
    thr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_lower <= thr_upper);

endmodule

// File: tb/test_sawtooth_regulator.sv
module test_sawtooth_regulator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cycle_en = 1'b0;
    logic [11:0] setpoint = '0;
    logic [11:0] sensor = '0;
    logic        reduce_en = 1'b0;
    logic        wide_hyst = 1'b0;
    logic        heat_req;
    logic        failsafe;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // Bench model state
    int  m_cnt = 0;
    bit  m_heat = 0;
    bit  m_fs = 0;

    always #5 clk = ~clk;

    sawtooth_regulator i_sawtooth_regulator (
        .clk       (clk),
        .rst_n     (rst_n),
        .cycle_en  (cycle_en),
        .setpoint  (setpoint),
        .sensor    (sensor),
        .reduce_en (reduce_en),
        .wide_hyst (wide_hyst),
        .heat_req  (heat_req),
        .failsafe  (failsafe)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %b expected %b (cnt %0d)", tag, what, act, exp, m_cnt);
        end
    endtask

    // Expected next outputs from the requirements.
    function automatic void predict(input int s, input int sp, input bit red, input bit wide,
                                    output bit eh, output bit ef);
        int ramp, up, lo, h;
        ramp = ((m_cnt >> 7) & 15) * 4;
        up = sp + ramp;
        if (up > 4095) up = 4095;
        if (red) up = (up >= 320) ? up - 320 : 0;
        h = wide ? 320 : 10;
        lo = (up >= h) ? up - h : 0;
        ef = (s > 3900);
        if (ef) eh = 0;
        else if (m_heat) eh = (s < up);
        else eh = (s < lo);
    endfunction

    task automatic enable_step(input int s, input int sp, input bit red, input bit wide, input string tag);
        bit eh, ef;
        @(negedge clk);
        sensor = 12'(s); setpoint = 12'(sp); reduce_en = red; wide_hyst = wide;
        cycle_en = 1'b1;
        predict(s, sp, red, wide, eh, ef);
        @(negedge clk);
        cycle_en = 1'b0;
        chk(tag, heat_req, eh, "heat_req");
        chk(tag, failsafe, ef, "failsafe");
        m_heat = eh; m_fs = ef;
        m_cnt = (m_cnt + 1) % 2048;
    endtask

    // Inputs move without an enable: nothing may change (R8).
    task automatic idle_scramble(input int seed);
        @(negedge clk);
        sensor = 12'((seed * 1237) % 4096);
        setpoint = 12'((seed * 611) % 4096);
        reduce_en = seed[0]; wide_hyst = seed[1];
        @(negedge clk);
        chk("R8", heat_req, m_heat, "heat_req hold");
        chk("R8", failsafe, m_fs, "failsafe hold");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", heat_req, 1'b0, "heat_req after reset");
        chk("R9", failsafe, 1'b0, "failsafe after reset");
        rst_n = 1'b1;

        // R1/R2/R10: two full ramp periods, sensor 30 codes above set-point
        for (int i = 0; i < 4096; i++) enable_step(1030, 1000, 0, 0, "R1/R2/R10");

        // R5/R6 wide band: turn-on can never be reached here
        for (int i = 0; i < 2048; i++) enable_step(900, 1000, 0, 1, "R6");

        // R3/R4/R5/R6/R7: sensor sweep across modes
        for (int s = 0; s < 4096; s += 3) enable_step(s, 2000, s[2], s[3], "R3/R4/R5/R6/R7");
        for (int s = 1700; s < 2100; s++) enable_step(s, 2000, s[0], s[1], "R5/R6");

        // R3: clamp at the top
        for (int i = 0; i < 2048; i++) enable_step(3890, 4090, 0, i[9], "R3");
        // R4: clamp at zero
        for (int i = 0; i < 512; i++) enable_step(0, 100, 1, 0, "R4");

        // R7: failsafe boundary
        for (int i = 0; i < 64; i++) enable_step(3900 + (i % 2), 4095, 0, 0, "R7");
        enable_step(3000, 4095, 0, 0, "R7");
        enable_step(3901, 4095, 0, 0, "R7");
        enable_step(2000, 4095, 0, 0, "R7");

        // R8: input changes without enables
        for (int i = 0; i < 200; i++) begin
            enable_step(1000 + (i % 80), 1000, 0, 0, "R8");
            idle_scramble(i);
        end

        // R9: reset takes priority over an enable mid-run
        for (int i = 0; i < 1500; i++) enable_step(1030, 1000, 0, 0, "R9");
        @(negedge clk);
        rst_n = 1'b0; cycle_en = 1'b1; sensor = 12'd0; setpoint = 12'd4000;
        @(negedge clk);
        rst_n = 1'b1; cycle_en = 1'b0;
        chk("R9", heat_req, 1'b0, "heat_req mid-run reset");
        chk("R9", failsafe, 1'b0, "failsafe mid-run reset");
        m_cnt = 0; m_heat = 0; m_fs = 0;
        for (int i = 0; i < 2048; i++) enable_step(1030, 1000, 0, 0, "R9/R10");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule